// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits on the host write path of a word-wide flash device. Each clock cycle with `wr_en` high carries one host write cycle, an address and a 16-bit data word. The decoder tracks these writes and recognises keyed command sequences of three or six cycles. The sequences control write protection, start a whole-array erase, and switch the device into or out of identification mode. The block also decides whether a plain data write may go into the page buffer, and it raises a one-cycle `word_wr` pulse for each write that is accepted.

The write-protection flag stands for a non-volatile bit. Its own initialisation input `nv_init_n` sets it. The ordinary reset `rst_n` stands for a power cycle: it clears the sequence tracker, identification mode and the open page window, and it leaves the flag unchanged. In identification mode, reads of word 0 and word 1 return the maker and device codes. Erase and programming timing live in other blocks. This block only emits `erase_start`, and it expects `load_close` when the neighbouring timer ends a page load.

All outputs except the read path are registered. A write presented in cycle n shows its effect on the outputs just after the clock edge that ends cycle n.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: The three writes AAAA@5555, 5555@2AAA, A0A0@5555 set `prot_en` and `page_open` to 1 after the clock edge that samples the third write.
- R2: The six writes AAAA@5555, 5555@2AAA, 8080@5555, AAAA@5555, 5555@2AAA, 2020@5555 clear `prot_en` to 0.
- R3: The same six-write prefix ending in 1010@5555 produces a one-cycle `erase_start` pulse. No other sixth word produces the pulse.
- R4: `id_mode` becomes 1 after either 9090@5555 as the third write of the three-write prefix, or 6060@5555 as the sixth write of the six-write prefix. It becomes 0 after F0F0@5555 as the third write of the three-write prefix.
- R5: When `rd_en` is high, `id_mode` is 1 and address bits above bit 0 are all zero, the read path gives `id_valid`=1 and `id_data` = 00DA for address 0 or 004F for address 1. In every other case `id_valid`=0 and `id_data`=0000.
- R6: A write that is not consumed by the sequence tracker pulses `word_wr` for one cycle only if `id_mode` is 0 and either `prot_en` is 0 or `page_open` is 1. With protection on and no preamble, a plain write gives no pulse.
- R7: `load_close` clears `page_open`, after which protected plain writes are refused again.
- R8: A write that advances or completes a sequence never pulses `word_wr`. A write that breaks a sequence returns the tracker to idle. If that write is AAAA@5555, it counts as the first write of a new sequence.
- R9: Only address bits 14..0 take part in command matching, so bit 15 of the address has no effect on recognition.
- R10: `nv_init_n` low sets `prot_en` to 1. `rst_n` low clears `id_mode`, `page_open` and the tracker, and leaves `prot_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-cycle reset (keeps protection flag) |
| nv_init_n | input | 1 | Active-low initialisation of the protection flag to enabled |
| wr_en | input | 1 | Host write cycle present this clock |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 16 | Host write data |
| load_close | input | 1 | Page load finished (from program timer) |
| rd_en | input | 1 | Host read cycle present |
| rd_addr | input | ADDR_W | Host read address |
| prot_en | output | 1 | Write protection flag |
| page_open | output | 1 | Page load window opened by preamble |
| word_wr | output | 1 | Data write accepted into page buffer (pulse) |
| erase_start | output | 1 | Chip-erase start pulse |
| id_mode | output | 1 | Identification mode active |
| id_valid | output | 1 | Read served with an identification word |
| id_data | output | 16 | Identification word, zero when not valid |

## Verification
The final word of each sequence is swept over all 256 values with a repeated byte, once after the six-write prefix and once after the three-write prefix. The six-write sweep shows that only 2020, 1010 and 6060 act, and that each has its own effect. The three-write sweep is run with protection off. It separates the words the tracker consumes (A0A0, 9090, F0F0, 8080, and the restart word AAAA) from those that fall through as data writes. Directed patterns cover these cases: a broken sequence with and without a restarting write, preambles sent with address bit 15 set, page windows closed by `load_close`, identification reads at several addresses, and resets applied with protection both on and off.

// File: rtl/ucd_pkg.sv
package ucd_pkg;
    localparam int UCD_DW  = 16;
    localparam int UCD_CAW = 15;

    localparam logic [UCD_CAW-1:0] KEY_ADR_A = 15'h5555;
    localparam logic [UCD_CAW-1:0] KEY_ADR_B = 15'h2AAA;

    localparam logic [UCD_DW-1:0] KEY_FIRST  = 16'hAAAA;
    localparam logic [UCD_DW-1:0] KEY_SECOND = 16'h5555;
    localparam logic [UCD_DW-1:0] CMD_PROT   = 16'hA0A0;
    localparam logic [UCD_DW-1:0] CMD_EXT    = 16'h8080;
    localparam logic [UCD_DW-1:0] CMD_ID3    = 16'h9090;
    localparam logic [UCD_DW-1:0] CMD_IDX    = 16'hF0F0;
    localparam logic [UCD_DW-1:0] CMD_UNPROT = 16'h2020;
    localparam logic [UCD_DW-1:0] CMD_ERASE  = 16'h1010;
    localparam logic [UCD_DW-1:0] CMD_ID6    = 16'h6060;

    localparam logic [UCD_DW-1:0] ID_MAKER  = 16'h00DA;
    localparam logic [UCD_DW-1:0] ID_DEVICE = 16'h004F;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_X3,
        SQ_X4,
        SQ_X5
    } seq_t;

    typedef struct packed {
        seq_t st;
        logic erase;
        logic id;
    } trk_t;

    typedef struct packed {
        logic page;
        logic word;
    } gate_t;
endpackage

// File: rtl/ucd_seq_fsm.sv
module ucd_seq_fsm
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [UCD_DW-1:0] wr_data,
    output logic              consumed,
    output logic              hit_pre,
    output logic              hit_unprot,
    output logic              erase_start,
    output logic              id_mode
);
    localparam int CAW = UCD_CAW;

    trk_t trk_d, trk_q;
    logic [CAW-1:0] key_adr;
    logic at_a, at_b, first_ok, step_ok;
    seq_t step_nx;

    assign key_adr  = wr_addr[CAW-1:0];
    assign at_a     = (key_adr == KEY_ADR_A);
    assign at_b     = (key_adr == KEY_ADR_B);
    assign first_ok = at_a && (wr_data == KEY_FIRST);

    always_comb begin
        trk_d      = trk_q;
        trk_d.erase = 1'b0;
        consumed   = 1'b0;
        hit_pre    = 1'b0;
        hit_unprot = 1'b0;
        step_ok    = 1'b0;
        step_nx    = SQ_IDLE;
        if (wr_en) begin
            unique case (trk_q.st)
                SQ_IDLE: begin
                    step_ok = first_ok;
                    step_nx = SQ_K1;
                end
                SQ_K1: begin
                    step_ok = at_b && (wr_data == KEY_SECOND);
                    step_nx = SQ_K2;
                end
                SQ_K2: begin
                    if (at_a) begin
                        unique case (wr_data)
                            CMD_PROT: begin step_ok = 1'b1; hit_pre = 1'b1; end
                            CMD_ID3:  begin step_ok = 1'b1; trk_d.id = 1'b1; end
                            CMD_IDX:  begin step_ok = 1'b1; trk_d.id = 1'b0; end
                            CMD_EXT:  begin step_ok = 1'b1; step_nx = SQ_X3; end
                            default:  step_ok = 1'b0;
                        endcase
                    end
                end
                SQ_X3: begin
                    step_ok = first_ok;
                    step_nx = SQ_X4;
                end
                SQ_X4: begin
                    step_ok = at_b && (wr_data == KEY_SECOND);
                    step_nx = SQ_X5;
                end
                SQ_X5: begin
                    if (at_a) begin
                        unique case (wr_data)
                            CMD_UNPROT: begin step_ok = 1'b1; hit_unprot = 1'b1; end
                            CMD_ERASE:  begin step_ok = 1'b1; trk_d.erase = 1'b1; end
                            CMD_ID6:    begin step_ok = 1'b1; trk_d.id = 1'b1; end
                            default:    step_ok = 1'b0;
                        endcase
                    end
                end
                default: step_ok = 1'b0;
            endcase
            if (step_ok) begin
                trk_d.st = step_nx;
                consumed = 1'b1;
            end else begin
                trk_d.st = first_ok ? SQ_K1 : SQ_IDLE;
                consumed = first_ok;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{st: SQ_IDLE, erase: 1'b0, id: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign erase_start = trk_q.erase;
    assign id_mode     = trk_q.id;

    AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start); // R3
    AST_ID_ENTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_a && trk_q.st == SQ_K2 && wr_data == CMD_IDX) |=> !id_mode); // R4
    AST_BREAK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !consumed) |=> (trk_q.st == SQ_IDLE)); // R8
endmodule

// File: rtl/ucd_guard.sv
module ucd_guard
    import ucd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nv_init_n,
    input  logic wr_en,
    input  logic consumed,
    input  logic id_mode,
    input  logic hit_pre,
    input  logic hit_unprot,
    input  logic load_close,
    output logic prot_en,
    output logic page_open,
    output logic word_wr
);
    gate_t gate_d, gate_q;
    logic  prot_d, prot_q;

    always_comb begin
        prot_d      = prot_q;
        gate_d      = gate_q;
        gate_d.word = 1'b0;
        if (load_close) begin
            gate_d.page = 1'b0;
        end
        if (hit_pre) begin
            prot_d      = 1'b1;
            gate_d.page = 1'b1;
        end
        if (hit_unprot) begin
            prot_d      = 1'b0;
            gate_d.page = 1'b0;
        end
        if (wr_en && !consumed && !id_mode && (!prot_q || gate_q.page)) begin
            gate_d.word = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge nv_init_n) begin
        if (!nv_init_n) begin
            prot_q <= 1'b1;
        end else begin
            prot_q <= prot_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '{page: 1'b0, word: 1'b0};
        end else begin
            gate_q <= gate_d;
        end
    end

    assign prot_en   = prot_q;
    assign page_open = gate_q.page;
    assign word_wr   = gate_q.word;

    AST_PRE_OPENS: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        hit_pre |=> (prot_en && page_open)); // R1
    AST_UNPROT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        hit_unprot |=> !prot_en); // R2
    AST_SEQ_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        consumed |=> !word_wr); // R8
    AST_CLOSE_SHUTS: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        (load_close && !hit_pre) |=> !page_open); // R7
endmodule

// File: rtl/ucd_id_rom.sv
module ucd_id_rom
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              id_mode,
    output logic              id_valid,
    output logic [UCD_DW-1:0] id_data
);
    logic upper_zero;

    assign upper_zero = (rd_addr[ADDR_W-1:1] == '0);

    always_comb begin
        id_valid = rd_en && id_mode && upper_zero;
        id_data  = '0;
        if (id_valid) begin
            id_data = rd_addr[0] ? ID_DEVICE : ID_MAKER;
        end
    end
endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_init_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              load_close,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prot_en,
    output logic              page_open,
    output logic              word_wr,
    output logic              erase_start,
    output logic              id_mode,
    output logic              id_valid,
    output logic [15:0]       id_data
);
    logic consumed, hit_pre, hit_unprot;

    ucd_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .consumed   (consumed),
        .hit_pre    (hit_pre),
        .hit_unprot (hit_unprot),
        .erase_start(erase_start),
        .id_mode    (id_mode)
    );

    ucd_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_init_n (nv_init_n),
        .wr_en     (wr_en),
        .consumed  (consumed),
        .id_mode   (id_mode),
        .hit_pre   (hit_pre),
        .hit_unprot(hit_unprot),
        .load_close(load_close),
        .prot_en   (prot_en),
        .page_open (page_open),
        .word_wr   (word_wr)
    );

    ucd_id_rom #(.ADDR_W(ADDR_W)) u_rom (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .id_mode (id_mode),
        .id_valid(id_valid),
        .id_data (id_data)
    );

    AST_ID_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> id_mode); // R5
    AST_ID_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> (id_data == ID_MAKER || id_data == ID_DEVICE)); // R5
    AST_WORD_GATED: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        word_wr |-> $past(!id_mode && (!prot_en || page_open))); // R6
endmodule

// File: tb/test_unlock_cmd_decoder.sv
module test_unlock_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nv_init_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          load_close = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          prot_en, page_open, word_wr, erase_start, id_mode, id_valid;
    logic [15:0]   id_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unlock_cmd_decoder #(.ADDR_W(AW)) i_unlock_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_close(load_close), .rd_en(rd_en), .rd_addr(rd_addr),
        .prot_en(prot_en), .page_open(page_open), .word_wr(word_wr),
        .erase_start(erase_start), .id_mode(id_mode),
        .id_valid(id_valid), .id_data(id_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic power_up();
        nv_init_n = 1'b0;
        rst_n     = 1'b0;
        @(posedge clk);
        #1;
        nv_init_n = 1'b1;
        rst_n     = 1'b1;
    endtask

    task automatic pulse_rst();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic pre3();
        wr(16'h5555, 16'hAAAA);
        wr(16'h2AAA, 16'h5555);
    endtask

    task automatic pre6();
        pre3();
        wr(16'h5555, 16'h8080);
        wr(16'h5555, 16'hAAAA);
        wr(16'h2AAA, 16'h5555);
    endtask

    task automatic rd(input logic [15:0] a);
        rd_addr = a;
        rd_en   = 1'b1;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        nv_init_n = 1'b1;
        rst_n     = 1'b1;

        // R10 reset state
        check("R10 prot after init", {15'd0, prot_en}, 16'd1);
        check("R10 page after init", {15'd0, page_open}, 16'd0);
        check("R10 id after init", {15'd0, id_mode}, 16'd0);
        check("R3 erase idle", {15'd0, erase_start}, 16'd0);

        // R6 protected plain write refused
        wr(16'h0123, 16'hBEEF);
        check("R6 protected plain write", {15'd0, word_wr}, 16'd0);

        // R1 preamble, then data accepted
        pre3();
        wr(16'h5555, 16'hA0A0);
        check("R1 prot set", {15'd0, prot_en}, 16'd1);
        check("R1 page opened", {15'd0, page_open}, 16'd1);
        check("R8 preamble word not data", {15'd0, word_wr}, 16'd0);
        wr(16'h0042, 16'h1234);
        check("R6 write in open page", {15'd0, word_wr}, 16'd1);
        idle_cycle();
        check("R6 pulse one cycle", {15'd0, word_wr}, 16'd0);

        // R7 load_close
        load_close = 1'b1;
        idle_cycle();
        load_close = 1'b0;
        check("R7 page closed", {15'd0, page_open}, 16'd0);
        wr(16'h0043, 16'h1111);
        check("R7 write after close", {15'd0, word_wr}, 16'd0);

        // R9 bit 15 ignored
        wr(16'hD555, 16'hAAAA);
        wr(16'hAAAA, 16'h5555);
        wr(16'hD555, 16'hA0A0);
        check("R9 preamble with bit15", {15'd0, page_open}, 16'd1);
        load_close = 1'b1;
        idle_cycle();
        load_close = 1'b0;

        // R8 break with restart word
        wr(16'h5555, 16'hAAAA);
        wr(16'h5555, 16'hAAAA);
        wr(16'h2AAA, 16'h5555);
        wr(16'h5555, 16'hA0A0);
        check("R8 restart opens page", {15'd0, page_open}, 16'd1);
        load_close = 1'b1;
        idle_cycle();
        load_close = 1'b0;

        // R8 break without restart
        wr(16'h5555, 16'hAAAA);
        wr(16'h0000, 16'h1234);
        wr(16'h2AAA, 16'h5555);
        wr(16'h5555, 16'hA0A0);
        check("R8 broken sequence lost", {15'd0, page_open}, 16'd0);

        // R4/R5 ID via three-write, reads
        pre3();
        wr(16'h5555, 16'h9090);
        check("R4 id entry 3", {15'd0, id_mode}, 16'd1);
        rd(16'h0000);
        check("R5 maker code", id_data, 16'h00DA);
        check("R5 maker valid", {15'd0, id_valid}, 16'd1);
        rd(16'h0001);
        check("R5 device code", id_data, 16'h004F);
        rd(16'h0002);
        check("R5 addr 2 data", id_data, 16'h0000);
        check("R5 addr 2 valid", {15'd0, id_valid}, 16'd0);
        rd(16'h8000);
        check("R5 addr bit15 valid", {15'd0, id_valid}, 16'd0);
        rd_en = 1'b0;
        #1;
        check("R5 no read", id_data, 16'h0000);
        pre3();
        wr(16'h5555, 16'hF0F0);
        check("R4 id exit", {15'd0, id_mode}, 16'd0);
        rd(16'h0000);
        check("R5 read outside id", {15'd0, id_valid}, 16'd0);
        rd_en = 1'b0;

        // R2 disable then plain writes allowed; ID blocks writes (R6)
        pre6();
        wr(16'h5555, 16'h2020);
        check("R2 prot cleared", {15'd0, prot_en}, 16'd0);
        wr(16'h0100, 16'h7777);
        check("R6 unprotected write", {15'd0, word_wr}, 16'd1);
        pre3();
        wr(16'h5555, 16'h9090);
        wr(16'h0100, 16'h7777);
        check("R6 id blocks write", {15'd0, word_wr}, 16'd0);

        // R10 power-cycle reset keeps flag off, clears id
        pulse_rst();
        check("R10 prot kept", {15'd0, prot_en}, 16'd0);
        check("R10 id cleared", {15'd0, id_mode}, 16'd0);
        power_up();
        check("R10 nv init sets prot", {15'd0, prot_en}, 16'd1);

        // R2 R3 R4 sweep of sixth word
        for (int k = 0; k < 256; k++) begin
            logic [15:0] d;
            d = {k[7:0], k[7:0]};
            power_up();
            pre6();
            wr(16'h5555, d);
            check("R3 sweep erase", {15'd0, erase_start}, {15'd0, (k == 'h10)});
            check("R4 sweep id6", {15'd0, id_mode}, {15'd0, (k == 'h60)});
            check("R2 sweep prot", {15'd0, prot_en}, {15'd0, (k != 'h20)});
            check("R6 sweep no write", {15'd0, word_wr}, 16'd0);
        end

        // R1 R4 R8 sweep of third word, protection off
        for (int k = 0; k < 256; k++) begin
            logic [15:0] d;
            logic        used;
            d = {k[7:0], k[7:0]};
            used = (k == 'hA0) || (k == 'h90) || (k == 'hF0) || (k == 'h80) || (k == 'hAA);
            power_up();
            pre6();
            wr(16'h5555, 16'h2020);
            pre3();
            wr(16'h5555, d);
            check("R1 sweep prot", {15'd0, prot_en}, {15'd0, (k == 'hA0)});
            check("R1 sweep page", {15'd0, page_open}, {15'd0, (k == 'hA0)});
            check("R4 sweep id3", {15'd0, id_mode}, {15'd0, (k == 'h90)});
            check("R8 sweep data fallthrough", {15'd0, word_wr}, {15'd0, !used});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule